// File: doc/BRIEF.md
# Down-Counting Pulse-Width Modulator with Buffered Width

This block generates one pulse-width modulated output from a 16-bit down-counter. The counter advances only on cycles where an external prescaled count-enable tick is high. When it reaches one it reloads from a period register, so a period value P gives a repeating sequence P, P-1, ..., 1. The output flip-flop turns on when the counter takes the value held in an active width register. It turns off when the counter leaves the value one at the end of the period.

Software sees three registers through a simple write/read port: the period, the width and a mode word. The mode word holds an enable bit and a bit that chooses between transparent and double-buffered width updates. Hardware never alters the software width register. The active copy used by the comparison is loaded directly on writes when the block is disabled or in transparent mode. In double-buffered mode it is loaded only at the end of a period. Period values 0, 1 and 2 have defined special behaviour: 0 gives a free-running count of 65536 ticks, 1 gives a constant level, and 2 gives the fastest square-ish output.

Top module: `dcpwm_top`

## Requirements
- R1: After reset, the period, width and mode registers read 0, the block is disabled and `pwm_o` is low.
- R2: Register addresses are 0 = period, 1 = width, 2 = mode (bit 0 enable, bit 1 buffered; other bits read 0), and 3 reads 0. A written value reads back unchanged, and hardware never modifies the width register.
- R3: A write that sets the enable bit while disabled loads the counter with the period. Each tick then decrements the counter, and a tick at count 1 reloads the period.
- R4: For period P >= 2 and active width 1 <= W < P, `pwm_o` rises on the tick that brings the count to W and falls on the tick that leaves count 1. The output is high for exactly W of every P ticks.
- R5: An active width of 0 never sets the output (0% duty).
- R6: A width equal to the period keeps the output permanently high. A width greater than the period never sets it.
- R7: With period 1, the counter stays at 1 and the output is constantly high for any nonzero width, and constantly low for width 0.
- R8: Period 0 makes the counter free-run through 0, 0xFFFF, ..., 1, giving a period of 65536 ticks.
- R9: In transparent mode (mode bit 1 = 0), a width write takes effect from the next tick.
- R10: In buffered mode (mode bit 1 = 1), a width write during a period does not affect that period. The new value is used from the reload onward.
- R11: While disabled, `pwm_o` is low, and a width write loads the active copy directly so it applies as soon as the block is enabled.
- R12: Without a tick, the counter and the output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled count-enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest case to reach is the double-buffered transfer. The stimulus has to land a width write in the middle of a running period, and the bench then has to show that the old width still governs the rest of that period while the new one governs the next. The bench counts ticks from the enable write, so it knows the counter value at every sample. It rewrites the width at a known count and samples the output at counts chosen to tell the two widths apart, on both sides of the reload. The free-running period-0 case is driven by holding the tick high for a full 65536-count cycle.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;
    typedef enum logic [1:0] {
        REG_PERIOD = 2'd0,
        REG_WIDTH  = 2'd1,
        REG_MODE   = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    localparam int MODE_EN_BIT  = 0;
    localparam int MODE_BUF_BIT = 1;
endpackage

// File: rtl/dcpwm_regs.sv
module dcpwm_regs
    import dcpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] width_sw_o,
    output logic             en_o,
    output logic             buf_o,
    output logic             width_wr_o,
    output logic             load_o,
    output logic             stop_o
);
    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
        logic             en;
        logic             buff;
    } regs_t;

    regs_t q, d;
    logic  mode_wr;

    always_comb begin
        d          = q;
        mode_wr    = wr_en_i && (wr_addr_i == REG_MODE);
        width_wr_o = wr_en_i && (wr_addr_i == REG_WIDTH);
        if (wr_en_i && (wr_addr_i == REG_PERIOD)) d.period = wr_data_i;
        if (width_wr_o) d.width = wr_data_i;
        if (mode_wr) begin
            d.en   = wr_data_i[MODE_EN_BIT];
            d.buff = wr_data_i[MODE_BUF_BIT];
        end
        load_o = mode_wr && !q.en && wr_data_i[MODE_EN_BIT];
        stop_o = mode_wr && q.en && !wr_data_i[MODE_EN_BIT];
        unique case (rd_addr_i)
            REG_PERIOD: rd_data_o = q.period;
            REG_WIDTH:  rd_data_o = q.width;
            REG_MODE: begin
                rd_data_o               = '0;
                rd_data_o[MODE_EN_BIT]  = q.en;
                rd_data_o[MODE_BUF_BIT] = q.buff;
            end
            default:    rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign period_o   = q.period;
    assign width_sw_o = q.width;
    assign en_o       = q.en;
    assign buf_o      = q.buff;

    assert_sw_width_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && (wr_addr_i == REG_WIDTH)) |=> $stable(q.width));
endmodule

// File: rtl/dcpwm_counter.sv
module dcpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             load_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             adv_o,
    output logic             pmatch_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d        = q;
        adv_o    = 1'b0;
        pmatch_o = 1'b0;
        if (load_i) begin
            d.cnt = period_i;
        end else if (!en_i || stop_i) begin
            d.cnt = '0;
        end else if (tick_i) begin
            adv_o = 1'b1;
            if (q.cnt == ONE) begin
                pmatch_o = 1'b1;
                d.cnt    = period_i;
            end else begin
                d.cnt = q.cnt - ONE;
            end
        end
        cnt_next_o = d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_hold_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i && !load_i && !stop_i) |=> $stable(q.cnt));
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pmatch_o |=> (q.cnt == $past(period_i)));
endmodule

// File: rtl/dcpwm_output.sv
module dcpwm_output #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             buf_i,
    input  logic             load_i,
    input  logic             stop_i,
    input  logic             adv_i,
    input  logic             pmatch_i,
    input  logic             width_wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] width_sw_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] act;
        logic             out;
    } out_t;

    out_t             q, d;
    logic [CNT_W-1:0] wcmp;
    logic             hit;
    logic             xfer;

    always_comb begin
        d    = q;
        xfer = pmatch_i && buf_i;
        wcmp = xfer ? width_sw_i : q.act;
        if (width_wr_i && (!en_i || !buf_i)) d.act = wr_data_i;
        if (xfer) d.act = width_sw_i;
        hit = (wcmp != '0) && ((period_i == ONE) || (cnt_next_i == wcmp));
        if (load_i) begin
            d.out = hit;
        end else if (!en_i || stop_i) begin
            d.out = 1'b0;
        end else if (adv_i) begin
            if (hit)           d.out = 1'b1;
            else if (pmatch_i) d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pwm_o = q.out;

    assert_off_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> !pwm_o);
    assert_buffer_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && buf_i && !pmatch_i) |=> $stable(q.act));
    assert_end_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && pmatch_i && !stop_i && (period_i != ONE) && (wcmp != period_i)) |=> !pwm_o);
    assert_period_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !stop_i && adv_i && (period_i == ONE) && (wcmp != '0)) |=> pwm_o);
endmodule

// File: rtl/dcpwm_top.sv
module dcpwm_top #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             pwm_o
);
    logic [CNT_W-1:0] period, width_sw, cnt_next;
    logic             en, buff, width_wr, load, stop, adv, pmatch;

    dcpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .period_o(period), .width_sw_o(width_sw), .en_o(en), .buf_o(buff),
        .width_wr_o(width_wr), .load_o(load), .stop_o(stop)
    );

    dcpwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en), .load_i(load),
        .stop_i(stop), .period_i(period), .cnt_next_o(cnt_next), .adv_o(adv),
        .pmatch_o(pmatch)
    );

    dcpwm_output #(.CNT_W(CNT_W)) u_output (
        .clk(clk), .rst_n(rst_n), .en_i(en), .buf_i(buff), .load_i(load),
        .stop_i(stop), .adv_i(adv), .pmatch_i(pmatch), .width_wr_i(width_wr),
        .wr_data_i(wr_data_i), .width_sw_i(width_sw), .period_i(period),
        .cnt_next_i(cnt_next), .pwm_o(pwm_o)
    );
endmodule

// File: tb/dcpwm_top_tb.sv
`timescale 1ns/1ps
module dcpwm_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pwm;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    dcpwm_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .pwm_o(pwm)
    );

    typedef struct packed {
        logic        buffered;
        logic [15:0] period;
        logic [15:0] width;
        logic [15:0] states;
        logic [15:0] highs;
    } vec_t;

    localparam vec_t VEC [0:11] = '{
        '{1'b0, 16'd5,  16'd2,  16'd10, 16'd4},   // R4
        '{1'b1, 16'd2,  16'd1,  16'd8,  16'd4},   // R4 fastest
        '{1'b0, 16'd10, 16'd9,  16'd20, 16'd18},  // R4 widest
        '{1'b1, 16'd8,  16'd3,  16'd24, 16'd9},   // R4
        '{1'b0, 16'd3,  16'd1,  16'd9,  16'd3},   // R4
        '{1'b0, 16'd7,  16'd7,  16'd14, 16'd14},  // R6 equal
        '{1'b1, 16'd4,  16'd9,  16'd8,  16'd0},   // R6 greater
        '{1'b0, 16'd6,  16'd0,  16'd12, 16'd0},   // R5
        '{1'b0, 16'd1,  16'd1,  16'd5,  16'd5},   // R7
        '{1'b1, 16'd1,  16'd3,  16'd5,  16'd5},   // R7
        '{1'b0, 16'd1,  16'd0,  16'd5,  16'd0},   // R7
        '{1'b1, 16'd16, 16'd16, 16'd16, 16'd16}   // R6
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic run_ticks(input int n, output int highs);
        highs = 0;
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm) highs++;
        end
        tick = 1'b0;
    endtask

    task automatic idle(input int n, output int changes);
        logic first;
        changes = 0;
        first = pwm;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm != first) changes++;
        end
    endtask

    task automatic start(input logic [15:0] p, input logic [15:0] w, input logic b);
        reg_wr(2'd2, 16'd0);
        reg_wr(2'd0, p);
        reg_wr(2'd1, w);
        reg_wr(2'd2, {14'd0, b, 1'b1});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int h;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(2'd0, v); check("R1 period", v, 0);
        reg_rd(2'd1, v); check("R1 width", v, 0);
        reg_rd(2'd2, v); check("R1 mode", v, 0);
        check("R1 pwm", pwm, 0);

        // Table walk: R4 R5 R6 R7
        foreach (VEC[i]) begin
            start(VEC[i].period, VEC[i].width, VEC[i].buffered);
            h = pwm ? 1 : 0;
            begin
                int more;
                run_ticks(int'(VEC[i].states) - 1, more);
                h += more;
            end
            check($sformatf("R4/R5/R6/R7 row%0d highs", i), h, int'(VEC[i].highs));
        end

        // R12 no tick holds state, then R3 count from load
        start(16'd4, 16'd2, 1'b0);
        check("R12 state4 low", pwm, 0);
        idle(20, c); check("R12 hold low", c, 0);
        run_ticks(2, h); check("R3 high at count 2", pwm, 1);
        idle(10, c); check("R12 hold high", c, 0);
        run_ticks(2, h); check("R4 low after reload", pwm, 0);

        // R8 period 0 free-running
        start(16'd0, 16'd3, 1'b0);
        check("R8 first state low", pwm, 0);
        run_ticks(65535, h); check("R8 highs over 65536", h, 3);
        check("R8 high at count 1", pwm, 1);
        run_ticks(1, h); check("R8 low after wrap", pwm, 0);

        // R9 transparent width update
        start(16'd10, 16'd2, 1'b0);
        run_ticks(2, h);
        reg_wr(2'd1, 16'd7);
        run_ticks(1, h); check("R9 new width at once", pwm, 1);

        // R10 buffered width update
        start(16'd10, 16'd2, 1'b1);
        run_ticks(2, h);
        reg_wr(2'd1, 16'd7);
        run_ticks(1, h); check("R10 old width kept at 7", pwm, 0);
        run_ticks(5, h); check("R10 old width at 2", pwm, 1);
        run_ticks(2, h); check("R10 low after reload", pwm, 0);
        run_ticks(3, h); check("R10 new width next period", pwm, 1);
        reg_rd(2'd1, v); check("R2 width untouched", v, 7);

        // R11 disabled write goes to active copy
        reg_wr(2'd2, 16'd0);
        @(negedge clk);
        check("R11 low when disabled", pwm, 0);
        reg_wr(2'd1, 16'd3);
        reg_wr(2'd0, 16'd5);
        run_ticks(4, h); check("R11 ticks ignored when disabled", h, 0);
        reg_wr(2'd2, 16'd3);
        h = pwm ? 1 : 0;
        begin
            int more;
            run_ticks(4, more);
            h += more;
        end
        check("R11 direct width applies", h, 3);

        // R2 readback
        reg_wr(2'd2, 16'hFFFF);
        reg_rd(2'd2, v); check("R2 mode bits", v, 3);
        reg_rd(2'd0, v); check("R2 period", v, 5);
        reg_rd(2'd3, v); check("R2 unused addr", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule